// File: doc/BRIEF.md
# Two-Wire Memory Card Bus Monitor

This block listens, without driving anything, to the three lines of a synchronous memory-card link. The three lines are a card reset line, a card clock and a shared data line. A faster system clock samples all three. From those samples the block finds reset/abort events, command start conditions and command stop conditions. It shifts data bits into bytes and labels every finished byte with the bus phase it belongs to: the card's answer to reset, a reader command, or card response data. A logic analyser front end or a security monitor can use it to turn raw bus activity into a stream of tagged bytes.

Each line passes through its own synchronizer. The block then compares the latest synchronized sample with the one before it to find edges. A priority decoder turns those edges into one bus event per system cycle. A four-state phase machine holds the current byte class. It has four states:
- `PH_IDLE`, the phase after block reset.
- `PH_ANSWER`, entered through the transition `T_RESET` on a card reset rise.
- `PH_COMMAND`, entered through `T_START` on a start condition.
- `PH_RESPONSE`, entered through `T_STOP` on a stop condition.

Any state can take any of the three transitions. A bit event leaves the phase unchanged (`T_HOLD`). The byte assembler counts data bits and emits a strobe after every eighth bit.

From a change on an input pin to the matching output pulse is three system clock edges: two synchronizer stages, then the output register.

Top module: `memcard_bus_monitor`

## Requirements
- R1: A rising edge on `card_rst_i` produces a one-cycle `reset_evt_o` pulse. It sets the class to answer-to-reset (code 1) and discards any partly received byte.
- R2: A data bit is taken only on a rising edge of `card_clk_i` while `card_rst_i` is low. Clock rises while `card_rst_i` is high add no bit.
- R3: Bits are placed least-significant first: the first bit taken after a clear becomes bit 0 of the byte.
- R4: Every eighth bit taken produces a one-cycle `byte_valid_o` pulse. `byte_data_o` holds the byte. `byte_class_o` holds the class current at that time: 0 = idle/reset, 1 = answer-to-reset, 2 = command, 3 = card data. Counting then restarts at bit 0.
- R5: A falling edge on `card_io_i` while `card_clk_i` is high is a start condition. It sets the class to command (code 2) and discards any partly received byte.
- R6: A rising edge on `card_io_i` while `card_clk_i` is high is a stop condition. It sets the class to card data (code 3) and discards any partly received byte.
- R7: After block reset (`rst_n` low), both strobes are low and the class is idle (code 0). Bytes that arrive before any bus event carry tag 0.
- R8: When several events fall in the same sample, they are ranked in this order: reset rise first, then bit capture, then start, then stop. A reset rise together with a clock rise takes no bit. A clock rise together with a data-line fall takes a bit and leaves the class unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Active-low synchronous block reset |
| card_rst_i | input | 1 | Card reset/abort line (asynchronous) |
| card_clk_i | input | 1 | Card serial clock (asynchronous) |
| card_io_i | input | 1 | Card data line (asynchronous) |
| byte_valid_o | output | 1 | One-cycle strobe, byte complete |
| byte_data_o | output | 8 | Completed byte, LSB received first |
| byte_class_o | output | 2 | Class tag of the completed byte |
| reset_evt_o | output | 1 | One-cycle strobe, card reset rise seen |

## Verification
The properties assume that every card line holds each level for at least one full system cycle. Under that assumption a synchronized edge cannot repeat in back-to-back cycles, and the single-cycle strobe checks rely on it. They also assume the data line changes only while the card clock is low, except when a start or stop condition is meant. The bench drives the lines only just after a falling system edge and holds each level for four system cycles. It sets up the data line with the card clock low and then raises the clock. It only lets two lines change in the same sample in the scenarios that test event ranking.

// File: rtl/mcm_pkg.sv
package mcm_pkg;

    // Phase of the bus, also the class tag attached to each byte.
    typedef enum logic [1:0] {
        PH_IDLE     = 2'd0,
        PH_ANSWER   = 2'd1,
        PH_COMMAND  = 2'd2,
        PH_RESPONSE = 2'd3
    } phase_e;

    // One decoded bus event per system cycle.
    typedef enum logic [2:0] {
        EV_NONE  = 3'd0,
        EV_RESET = 3'd1,
        EV_BIT   = 3'd2,
        EV_START = 3'd3,
        EV_STOP  = 3'd4
    } bus_evt_e;

    localparam int unsigned LINE_RST = 0;
    localparam int unsigned LINE_CLK = 1;
    localparam int unsigned LINE_IO  = 2;
    localparam int unsigned N_LINES  = 3;

endpackage

// File: rtl/mcm_line_sync.sv
module mcm_line_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic level_o,
    output logic prev_o
);
    localparam int unsigned LAST = STAGES - 1;

    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
            prev_q  <= 1'b0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], raw_i};
            prev_q  <= chain_q[LAST];
        end
    end

    assign level_o = chain_q[LAST];
    assign prev_o  = prev_q;

endmodule

// File: rtl/mcm_event_arb.sv
module mcm_event_arb
    import mcm_pkg::*;
(
    input  logic     rst_rise_i,
    input  logic     rst_lvl_i,
    input  logic     clk_rise_i,
    input  logic     clk_lvl_i,
    input  logic     io_rise_i,
    input  logic     io_fall_i,
    output bus_evt_e evt_o
);
    // Fixed ranking: reset, bit, start, stop.
    always_comb begin
        if (rst_rise_i)
            evt_o = EV_RESET;
        else if (clk_rise_i && !rst_lvl_i)
            evt_o = EV_BIT;
        else if (clk_lvl_i && io_fall_i)
            evt_o = EV_START;
        else if (clk_lvl_i && io_rise_i)
            evt_o = EV_STOP;
        else
            evt_o = EV_NONE;
    end

endmodule

// File: rtl/mcm_phase_fsm.sv
module mcm_phase_fsm
    import mcm_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  bus_evt_e evt_i,
    output phase_e   phase_o,
    output logic     clear_o,
    output logic     reset_evt_o
);
    phase_e state_q, state_d;
    logic   reset_evt_q;

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= PH_IDLE;
        else
            state_q <= state_d;
    end

    // Transitions: T_RESET, T_START, T_STOP, otherwise T_HOLD.
    always_comb begin
        state_d = state_q;
        unique case (evt_i)
            EV_RESET: state_d = PH_ANSWER;
            EV_START: state_d = PH_COMMAND;
            EV_STOP:  state_d = PH_RESPONSE;
            EV_BIT,
            EV_NONE:  state_d = state_q;
            default:  state_d = state_q;
        endcase
    end

    // Output process.
    always_ff @(posedge clk) begin
        if (!rst_n)
            reset_evt_q <= 1'b0;
        else
            reset_evt_q <= (evt_i == EV_RESET);
    end

    assign phase_o     = state_q;
    assign clear_o     = (evt_i == EV_RESET) || (evt_i == EV_START) || (evt_i == EV_STOP);
    assign reset_evt_o = reset_evt_q;

endmodule

// File: rtl/mcm_byte_asm.sv
module mcm_byte_asm
    import mcm_pkg::*;
#(
    parameter int unsigned WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en_i,
    input  logic              bit_val_i,
    input  logic              clear_i,
    input  phase_e            phase_i,
    output logic              valid_o,
    output logic [WORD_W-1:0] data_o,
    output phase_e            class_o
);
    localparam int unsigned CNT_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(WORD_W - 1);

    logic [CNT_W-1:0]  cnt_q;
    logic [WORD_W-1:0] acc_q, acc_d;
    logic              valid_q;
    logic [WORD_W-1:0] data_q;
    phase_e            class_q;

    // Place the incoming bit at the current count (LSB first).
    always_comb begin
        acc_d = acc_q;
        acc_d[cnt_q] = bit_val_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            acc_q   <= '0;
            valid_q <= 1'b0;
            data_q  <= '0;
            class_q <= PH_IDLE;
        end else begin
            valid_q <= 1'b0;
            if (clear_i) begin
                cnt_q <= '0;
                acc_q <= '0;
            end else if (bit_en_i) begin
                if (cnt_q == LAST_IDX) begin
                    cnt_q   <= '0;
                    acc_q   <= '0;
                    valid_q <= 1'b1;
                    data_q  <= acc_d;
                    class_q <= phase_i;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                    acc_q <= acc_d;
                end
            end
        end
    end

    assign valid_o = valid_q;
    assign data_o  = data_q;
    assign class_o = class_q;

endmodule

// File: rtl/memcard_bus_monitor.sv
module memcard_bus_monitor
    import mcm_pkg::*;
#(
    parameter int unsigned WORD_W      = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              card_rst_i,
    input  logic              card_clk_i,
    input  logic              card_io_i,
    output logic              byte_valid_o,
    output logic [WORD_W-1:0] byte_data_o,
    output logic [1:0]        byte_class_o,
    output logic              reset_evt_o
);
    logic [N_LINES-1:0] raw;
    logic [N_LINES-1:0] lvl;
    logic [N_LINES-1:0] prv;

    assign raw[LINE_RST] = card_rst_i;
    assign raw[LINE_CLK] = card_clk_i;
    assign raw[LINE_IO]  = card_io_i;

    for (genvar g = 0; g < N_LINES; g++) begin : g_sync
        mcm_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk     (clk),
            .rst_n   (rst_n),
            .raw_i   (raw[g]),
            .level_o (lvl[g]),
            .prev_o  (prv[g])
        );
    end

    logic rst_lvl, clk_lvl;
    logic rst_rise, clk_rise, io_rise, io_fall;

    assign rst_lvl  = lvl[LINE_RST];
    assign clk_lvl  = lvl[LINE_CLK];
    assign rst_rise = lvl[LINE_RST] & ~prv[LINE_RST];
    assign clk_rise = lvl[LINE_CLK] & ~prv[LINE_CLK];
    assign io_rise  = lvl[LINE_IO]  & ~prv[LINE_IO];
    assign io_fall  = ~lvl[LINE_IO] &  prv[LINE_IO];

    bus_evt_e evt;
    phase_e   cur_phase;
    phase_e   out_class;
    logic     clear;

    mcm_event_arb u_arb (
        .rst_rise_i (rst_rise),
        .rst_lvl_i  (rst_lvl),
        .clk_rise_i (clk_rise),
        .clk_lvl_i  (clk_lvl),
        .io_rise_i  (io_rise),
        .io_fall_i  (io_fall),
        .evt_o      (evt)
    );

    mcm_phase_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .evt_i       (evt),
        .phase_o     (cur_phase),
        .clear_o     (clear),
        .reset_evt_o (reset_evt_o)
    );

    mcm_byte_asm #(.WORD_W(WORD_W)) u_asm (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_en_i  (evt == EV_BIT),
        .bit_val_i (lvl[LINE_IO]),
        .clear_i   (clear),
        .phase_i   (cur_phase),
        .valid_o   (byte_valid_o),
        .data_o    (byte_data_o),
        .class_o   (out_class)
    );

    assign byte_class_o = out_class;

endmodule

// File: rtl/mcm_checker.sv
module mcm_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       reset_evt_o,
    input logic       byte_valid_o,
    input logic [1:0] byte_class_o,
    input logic [1:0] cur_phase,
    input logic       rst_lvl,
    input logic       clk_lvl,
    input logic       rst_rise,
    input logic       clk_rise,
    input logic       io_rise,
    input logic       io_fall
);
    // R1
    rst_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reset_evt_o |=> !reset_evt_o);

    // R1
    rst_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reset_evt_o |-> cur_phase == 2'd1);

    // R2
    rst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_lvl |=> !byte_valid_o);

    // R4
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid_o |=> !byte_valid_o);

    // R4
    valid_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid_o |-> byte_class_o == cur_phase);

    // R5
    start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_fall && clk_lvl && !rst_rise && !(clk_rise && !rst_lvl)) |=> cur_phase == 2'd2);

    // R6
    stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rise && clk_lvl && !rst_rise && !(clk_rise && !rst_lvl)) |=> cur_phase == 2'd3);

    // R8
    excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(reset_evt_o && byte_valid_o));

endmodule

bind memcard_bus_monitor mcm_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .reset_evt_o  (reset_evt_o),
    .byte_valid_o (byte_valid_o),
    .byte_class_o (byte_class_o),
    .cur_phase    (cur_phase),
    .rst_lvl      (rst_lvl),
    .clk_lvl      (clk_lvl),
    .rst_rise     (rst_rise),
    .clk_rise     (clk_rise),
    .io_rise      (io_rise),
    .io_fall      (io_fall)
);

// File: tb/tb_memcard_bus_monitor.sv
`timescale 1ns/1ps
module tb_memcard_bus_monitor;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       card_rst = 1'b0;
    logic       card_clk = 1'b0;
    logic       card_io = 1'b1;
    logic       byte_valid_o;
    logic [7:0] byte_data_o;
    logic [1:0] byte_class_o;
    logic       reset_evt_o;

    int tests = 0;
    int fails = 0;
    int nbytes = 0;
    int nresets = 0;
    logic [7:0] got_data [0:63];
    logic [1:0] got_class [0:63];
    logic prev_valid = 1'b0;
    logic prev_rst = 1'b0;

    always #10 clk = ~clk;

    memcard_bus_monitor dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .card_rst_i   (card_rst),
        .card_clk_i   (card_clk),
        .card_io_i    (card_io),
        .byte_valid_o (byte_valid_o),
        .byte_data_o  (byte_data_o),
        .byte_class_o (byte_class_o),
        .reset_evt_o  (reset_evt_o)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Record output strobes away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (byte_valid_o) begin
                if (nbytes < 64) begin
                    got_data[nbytes]  = byte_data_o;
                    got_class[nbytes] = byte_class_o;
                end
                nbytes++;
                if (prev_valid) check(1'b0, "R4", "valid longer than one cycle", 1, 0);
            end
            if (reset_evt_o) begin
                nresets++;
                if (prev_rst) check(1'b0, "R1", "reset pulse longer than one cycle", 1, 0);
            end
        end
        prev_valid = byte_valid_o;
        prev_rst   = reset_evt_o;
    end

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic send_bit(input logic b);
        card_clk = 1'b0; settle();
        card_io  = b;    settle();
        card_clk = 1'b1; settle();
    endtask

    task automatic send_byte(input logic [7:0] v);
        for (int i = 0; i < 8; i++) send_bit(v[i]);
    endtask

    task automatic cmd_start();
        card_clk = 1'b0; settle();
        card_io  = 1'b1; settle();
        card_clk = 1'b1; settle();
        card_io  = 1'b0; settle();
    endtask

    task automatic cmd_stop();
        card_clk = 1'b0; settle();
        card_io  = 1'b0; settle();
        card_clk = 1'b1; settle();
        card_io  = 1'b1; settle();
    endtask

    task automatic expect_byte(input int base, input logic [7:0] d, input logic [1:0] c,
                               input string req);
        check(nbytes == base + 1, req, "byte count", nbytes, base + 1);
        if (nbytes == base + 1) begin
            check(got_data[base] == d, req, "byte value", got_data[base], d);
            check(got_class[base] == c, req, "class tag", got_class[base], c);
        end
    endtask

    // R7: reset state, then a byte with no bus event (also R3, R4)
    task automatic t_reset_state();
        int b = nbytes;
        check(byte_valid_o == 1'b0, "R7", "valid after reset", byte_valid_o, 0);
        check(reset_evt_o == 1'b0, "R7", "reset pulse after reset", reset_evt_o, 0);
        send_byte(8'hA5);
        expect_byte(b, 8'hA5, 2'd0, "R7");
        b = nbytes;
        send_byte(8'h01);
        expect_byte(b, 8'h01, 2'd0, "R3");
    endtask

    // R1 and R2: reset rise, clocks ignored while high
    task automatic t_reset_event();
        int b = nbytes;
        int r = nresets;
        card_clk = 1'b0; settle();
        card_rst = 1'b1; settle();
        check(nresets == r + 1, "R1", "reset pulse count", nresets, r + 1);
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
        card_rst = 1'b0; settle();
        check(nbytes == b, "R2", "no byte while reset high", nbytes, b);
        send_byte(8'h3C);
        expect_byte(b, 8'h3C, 2'd1, "R2");
    endtask

    // R1: partial byte discarded by a reset rise
    task automatic t_reset_discard();
        int b = nbytes;
        for (int i = 0; i < 5; i++) send_bit(1'b1);
        card_clk = 1'b0; settle();
        card_rst = 1'b1; settle();
        card_rst = 1'b0; settle();
        send_byte(8'h81);
        expect_byte(b, 8'h81, 2'd1, "R1");
    endtask

    // R5: start condition discards partial bits, sets command class
    task automatic t_start();
        int b = nbytes;
        send_bit(1'b1); send_bit(1'b1); send_bit(1'b0);
        cmd_start();
        check(nbytes == b, "R5", "no byte from partial bits", nbytes, b);
        send_byte(8'h5A);
        expect_byte(b, 8'h5A, 2'd2, "R5");
    endtask

    // R6: stop condition sets data class; back-to-back bytes restart count (R4)
    task automatic t_stop();
        int b = nbytes;
        send_bit(1'b0); send_bit(1'b1);
        cmd_stop();
        check(nbytes == b, "R6", "no byte from partial bits", nbytes, b);
        send_byte(8'hC3);
        expect_byte(b, 8'hC3, 2'd3, "R6");
        b = nbytes;
        send_byte(8'h80);
        expect_byte(b, 8'h80, 2'd3, "R4");
        b = nbytes;
        send_byte(8'h7E);
        expect_byte(b, 8'h7E, 2'd3, "R4");
    endtask

    // R8: same-sample events ranked
    task automatic t_priority();
        int b = nbytes;
        int r = nresets;
        // Clock rise with data-line fall: bit taken, class kept (data).
        card_clk = 1'b0; settle();
        card_io  = 1'b1; settle();
        @(negedge clk);
        card_clk = 1'b1; card_io = 1'b0; settle();
        for (int i = 1; i < 8; i++) send_bit(1'b1);
        expect_byte(b, 8'hFE, 2'd3, "R8");
        // Reset rise with clock rise: reset wins, no bit.
        b = nbytes;
        card_clk = 1'b0; settle();
        @(negedge clk);
        card_rst = 1'b1; card_clk = 1'b1; settle();
        check(nresets == r + 1, "R8", "reset pulse on joint edge", nresets, r + 1);
        card_clk = 1'b0; settle();
        card_rst = 1'b0; settle();
        send_byte(8'h77);
        expect_byte(b, 8'h77, 2'd1, "R8");
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        settle();
        t_reset_state();
        t_reset_event();
        t_reset_discard();
        t_start();
        t_stop();
        t_priority();
        settle();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule